// File: doc/BRIEF.md
# Data Wait Timeout Counter

This block guards the wait for data from a memory card. When a transfer is armed it counts card-clock ticks, marked by a one-cycle enable pulse in the system clock domain, and compares the count with a limit. The limit comes from a 7-bit setting word that holds a 4-bit tick count and a 3-bit scale code. The scale code picks a left shift for the tick count from a fixed, uneven set of amounts. Any data activity on the card bus puts the count back to zero. If the count reaches the limit before the transfer is stopped, the block raises a sticky timeout error.

The controller around the block arms it together with a data command. It pulses the activity input whenever a data bit, block or busy release is seen, and drops the wait with the halt input when the transfer ends or is aborted. The setting word is captured when the block is armed, so software may rewrite it during a running wait without effect. The counter is wide enough for the largest limit, 15 shifted left by 20 (15,728,640 ticks).

Top module: `dto_watch`

## Requirements
- R1: While reset is asserted and after its release, with no start, `tmo_err` and `busy` are 0.
- R2: `tmo_cfg[3:0]` is the tick count and `tmo_cfg[6:4]` is the scale code. Codes 0 through 7 shift the tick count left by 0, 4, 7, 8, 10, 12, 16 and 20 bits, and the result is the limit in card-clock ticks.
- R3: The counter holds the largest limit (15 shifted by 20) without wrapping, so with code 7 and count 15 no timeout occurs early.
- R4: The count advances only on cycles where `tick_en` is 1 while `busy` is 1. Without ticks, `busy` stays 1 and no timeout occurs.
- R5: A cycle with `arm` at 1 clears `tmo_err`, sets `busy`, zeroes the count and captures `tmo_cfg`. Later changes to `tmo_cfg` do not move the limit of the running wait.
- R6: A cycle with `activity` at 1 while busy sets the count to zero. This takes precedence over a tick in the same cycle, so a full limit of further ticks is needed.
- R7: A cycle with `halt` at 1 and `arm` at 0 ends the wait: `busy` goes to 0 and `tmo_err` keeps its value.
- R8: On the tick that brings the count to the limit, `tmo_err` becomes 1 and `busy` becomes 0 on the following clock edge. With limit L ≥ 1 this is the L-th tick after the start or the last restart. `tmo_err` and `busy` are never 1 together.
- R9: A limit of zero raises the timeout on the first tick after the start.
- R10: `tmo_err` stays at 1 through further ticks and halts, until `arm` is asserted or reset is asserted.
- R11: When `arm` and `halt` are both 1 in one cycle, `arm` wins and `busy` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | One-cycle pulse per card-clock period |
| arm | input | 1 | Start a wait and capture the setting word |
| activity | input | 1 | Data activity pulse that restarts the count |
| halt | input | 1 | Transfer finished or aborted; ends the wait |
| tmo_cfg | input | 7 | Setting word: [3:0] tick count, [6:4] scale code |
| tmo_err | output | 1 | Sticky data timeout error |
| busy | output | 1 | A wait is being timed |

## Verification
The assertions assume that the controller gives every input a defined value after reset, and that `arm`, `halt` and `activity` are single-cycle pulses. Repeated pulses are legal but would only recheck the same rules. The bench drives every input on the falling clock edge, so each control pulse is seen at exactly one rising edge. Start and halt are sent alone or in the one combination R11 names, and ticks are counted in the bench until the error appears. The scale codes up to 6 are timed end to end. Code 7 is only checked for the absence of an early timeout, because its full limit would run past the cycle budget.

// File: rtl/dto_pkg.sv
package dto_pkg;

  localparam int unsigned CODE_W = 3;

  // Left shift chosen by each scale code; the spacing is deliberately uneven.
  function automatic logic [4:0] shift_of(input logic [CODE_W-1:0] code);
    logic [4:0] s;
    case (code)
      3'd0:    s = 5'd0;
      3'd1:    s = 5'd4;
      3'd2:    s = 5'd7;
      3'd3:    s = 5'd8;
      3'd4:    s = 5'd10;
      3'd5:    s = 5'd12;
      3'd6:    s = 5'd16;
      default: s = 5'd20;
    endcase
    return s;
  endfunction

  localparam int unsigned MAX_SHIFT = 20;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_ZERO = 2'd1,
    CNT_INC  = 2'd2
  } cnt_act_e;

endpackage

// File: rtl/dto_limit.sv
module dto_limit
  import dto_pkg::*;
#(
  parameter int unsigned CYC_W = 4,
  parameter int unsigned CNT_W = CYC_W + MAX_SHIFT,
  localparam int unsigned CFG_W = CYC_W + CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] limit
);

  logic [CYC_W-1:0]  cyc_field;
  logic [CODE_W-1:0] code_field;
  logic [4:0]        shamt;
  logic [CNT_W-1:0]  limit_d;
  logic [CNT_W-1:0]  limit_q;

  assign cyc_field  = cfg[CYC_W-1:0];
  assign code_field = cfg[CFG_W-1:CYC_W];
  assign shamt      = shift_of(code_field);

  always_comb begin
    limit_d = limit_q;
    if (load) begin
      limit_d = CNT_W'(cyc_field) << shamt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else begin
      limit_q <= limit_d;
    end
  end

  assign limit = limit_q;

endmodule

// File: rtl/dto_count.sv
module dto_count
  import dto_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_act_e         act,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [CNT_W:0]   count_inc;

  assign count_inc = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};

  // Limit reached on this tick (a zero limit matches the first tick).
  assign hit = (act == CNT_INC) && (count_inc >= {1'b0, limit});

  always_comb begin
    count_d = count_q;
    case (act)
      CNT_ZERO: count_d = '0;
      CNT_INC:  count_d = hit ? '0 : count_inc[CNT_W-1:0];
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/dto_ctrl.sv
module dto_ctrl
  import dto_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_en,
  input  logic     arm,
  input  logic     activity,
  input  logic     halt,
  input  logic     hit,
  output cnt_act_e act,
  output logic     busy,
  output logic     err
);

  logic busy_q, busy_d;
  logic err_q, err_d;

  // Counter action: start > halt > activity > tick.
  always_comb begin
    act = CNT_HOLD;
    if (arm) begin
      act = CNT_ZERO;
    end else if (busy_q) begin
      if (halt || activity) begin
        act = CNT_ZERO;
      end else if (tick_en) begin
        act = CNT_INC;
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    if (arm) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
    end else if (busy_q) begin
      if (halt) begin
        busy_d = 1'b0;
      end else if (hit) begin
        busy_d = 1'b0;
        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  assign busy = busy_q;
  assign err  = err_q;

endmodule

// File: rtl/dto_watch.sv
module dto_watch
  import dto_pkg::*;
#(
  parameter int unsigned CYC_W = 4,
  localparam int unsigned CFG_W = CYC_W + CODE_W,
  localparam int unsigned CNT_W = CYC_W + MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             arm,
  input  logic             activity,
  input  logic             halt,
  input  logic [CFG_W-1:0] tmo_cfg,
  output logic             tmo_err,
  output logic             busy
);

  logic [CNT_W-1:0] limit;
  logic             hit;
  cnt_act_e         act;

  dto_limit #(.CYC_W(CYC_W), .CNT_W(CNT_W)) u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (arm),
    .cfg   (tmo_cfg),
    .limit (limit)
  );

  dto_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .limit (limit),
    .hit   (hit)
  );

  dto_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .arm      (arm),
    .activity (activity),
    .halt     (halt),
    .hit      (hit),
    .act      (act),
    .busy     (busy),
    .err      (tmo_err)
  );

endmodule

// File: rtl/dto_watch_chk.sv
module dto_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic arm,
  input logic activity,
  input logic halt,
  input logic tmo_err,
  input logic busy
);

  a_r5_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (busy && !tmo_err));

  a_r7_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !arm) |=> !busy);

  a_r11_arm_over_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && halt) |=> busy);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !arm) |=> tmo_err);

  a_r8_err_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> $past(busy && tick_en && !halt && !activity && !arm));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && tmo_err));

  a_r4_idle_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en && !halt) |=> busy);

endmodule

bind dto_watch dto_watch_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .arm      (arm),
  .activity (activity),
  .halt     (halt),
  .tmo_err  (tmo_err),
  .busy     (busy)
);

// File: tb/dto_watch_test.sv
`timescale 1ns/1ps
module dto_watch_test;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       arm;
  logic       activity;
  logic       halt;
  logic [6:0] tmo_cfg;
  logic       tmo_err;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  dto_watch uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .arm      (arm),
    .activity (activity),
    .halt     (halt),
    .tmo_cfg  (tmo_cfg),
    .tmo_err  (tmo_err),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int shift_amt(input int code);
    case (code)
      0: return 0;
      1: return 4;
      2: return 7;
      3: return 8;
      4: return 10;
      5: return 12;
      6: return 16;
      default: return 20;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [6:0] cfg);
    @(negedge clk);
    tmo_cfg = cfg; arm = 1'b1; halt = 1'b0; activity = 1'b0; tick_en = 1'b0;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  // Ticks every cycle until the error appears; returns the tick count.
  task automatic ticks_to_err(input int maxn, output int n);
    n = 0;
    tick_en = 1'b1;
    while (n < maxn) begin
      @(negedge clk);
      n++;
      if (tmo_err) break;
    end
    tick_en = 1'b0;
  endtask

  task automatic run_ticks(input int k);
    tick_en = 1'b1;
    repeat (k) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick_en = 1'b0; arm = 1'b0; activity = 1'b0; halt = 1'b0;
    tmo_cfg = 7'h00;
    repeat (3) @(negedge clk);
    check(tmo_err == 1'b0 && busy == 1'b0, "R1 in reset", {tmo_err, busy}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tmo_err == 1'b0 && busy == 1'b0, "R1 after release", {tmo_err, busy}, 0);
  endtask

  task automatic t_limit(input int cnt, input int code);
    int n;
    int exp;
    exp = cnt << shift_amt(code);
    start(7'((code << 4) | cnt));
    ticks_to_err(exp + 5, n);
    check(n == exp, $sformatf("R2 limit count=%0d code=%0d", cnt, code), n, exp);
    check(busy == 1'b0, "R8 busy drops on timeout", busy, 0);
  endtask

  task automatic t_zero();
    int n;
    start(7'h50);
    ticks_to_err(5, n);
    check(n == 1, "R9 zero count times out on first tick", n, 1);
  endtask

  task automatic t_wide();
    start(7'h7F);
    run_ticks(30000);
    check(tmo_err == 1'b0 && busy == 1'b1, "R3 largest limit no early timeout",
          {tmo_err, busy}, 1);
    pulse_halt();
  endtask

  task automatic t_gate();
    int n;
    start(7'h02);
    repeat (50) @(negedge clk);
    check(tmo_err == 1'b0 && busy == 1'b1, "R4 no ticks no timeout", {tmo_err, busy}, 1);
    ticks_to_err(10, n);
    check(n == 2, "R4 ticks then counted", n, 2);
  endtask

  task automatic t_restart();
    int n;
    start(7'h0A);
    run_ticks(6);
    tick_en = 1'b1; activity = 1'b1;
    @(negedge clk);
    activity = 1'b0; tick_en = 1'b0;
    check(busy == 1'b1, "R6 still busy after activity", busy, 1);
    ticks_to_err(20, n);
    check(n == 10, "R6 restart needs full limit", n, 10);
  endtask

  task automatic t_halt();
    start(7'h05);
    run_ticks(2);
    pulse_halt();
    check(busy == 1'b0 && tmo_err == 1'b0, "R7 halt ends wait, no error", {busy, tmo_err}, 0);
    run_ticks(20);
    check(tmo_err == 1'b0, "R7 ticks after halt ignored", tmo_err, 0);
  endtask

  task automatic t_sticky();
    int n;
    start(7'h03);
    ticks_to_err(10, n);
    run_ticks(20);
    check(tmo_err == 1'b1, "R10 error holds through ticks", tmo_err, 1);
    pulse_halt();
    check(tmo_err == 1'b1, "R10 error holds through halt", tmo_err, 1);
    start(7'h03);
    check(tmo_err == 1'b0 && busy == 1'b1, "R5 start clears error", {tmo_err, busy}, 1);
    ticks_to_err(10, n);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(tmo_err == 1'b0, "R10 reset clears error", tmo_err, 0);
  endtask

  task automatic t_capture();
    int n;
    start(7'h04);
    tmo_cfg = 7'h7F;
    ticks_to_err(10, n);
    check(n == 4, "R5 setting captured at start", n, 4);
  endtask

  task automatic t_prio();
    @(negedge clk);
    tmo_cfg = 7'h05; arm = 1'b1; halt = 1'b1;
    @(negedge clk);
    arm = 1'b0; halt = 1'b0;
    check(busy == 1'b1, "R11 start wins over halt", busy, 1);
    pulse_halt();
  endtask

  initial begin
    t_reset();
    t_limit(3, 0);
    t_limit(1, 1);
    t_limit(1, 2);
    t_limit(5, 2);
    t_limit(1, 3);
    t_limit(1, 4);
    t_limit(1, 5);
    t_limit(1, 6);
    t_zero();
    t_wide();
    t_gate();
    t_restart();
    t_halt();
    t_sticky();
    t_capture();
    t_prio();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule